// File: doc/BRIEF.md
# Single-Wire Wake and Sleep Controller

This block controls the power state of a device that hangs off a single-wire serial bus. After power-on the device sleeps and ignores the bus. The host wakes it by pulling the line low for longer than a deglitch window. When that window expires, the controller releases the core reset. It then reads a few default configuration bytes from a small one-time-programmable memory and pulls the line low itself for a fixed fraction of a bit time. That pull-down is the ready break, and it is sent whether or not the host has already let go of the line.

Once awake, the controller watches the line for edges. If no edge arrives for a long idle interval, it puts the device back to sleep. This happens whether the line rests high or low. Auto-sleep can be switched off by a control write. It is disabled for good when a fused bit of configuration byte 0 is cleared.

All intervals are counted in ticks of a prescaled strobe (`time_tick`), so a test configuration can shrink them. The configuration reads use a valid/ready handshake. The controller raises `cfg_rd_valid` with an address and holds both the request and the address unchanged for as long as `cfg_rd_ready` stays low. The memory model may stall for any number of cycles. A byte is taken from `cfg_rd_data` in the cycle where valid and ready are both high. The next address, if any, follows in the next cycle.

Top module: `swire_power_ctl`

## Requirements
- R1: While reset is asserted and right after it, `sleep_flag` is 1, `core_rst_n` is 0, `bus_pull_dn` is 0 and `cfg_rd_valid` is 0.
- R2: While asleep, the following leave the device asleep and start no configuration read: a line resting high or low, a rising edge, and a low pulse that covers fewer than DEGLITCH_TICKS ticks.
- R3: A low level that starts with a falling edge while asleep and covers DEGLITCH_TICKS ticks wakes the device. At that tick `sleep_flag` goes to 0 and `core_rst_n` goes to 1, never earlier.
- R4: On waking, addresses 0 to CFG_BYTES-1 are read in ascending order, one per handshake. Valid and address stay stable while ready is low. Byte k lands in `dflt_cfg[8k+7:8k]`.
- R5: `bus_pull_dn` rises in the cycle after the last configuration handshake, even while the host still holds the line low. It stays high for exactly ceil(1391*BIT_TICKS/1000) ticks.
- R6: While awake with auto-sleep in force, IDLE_TICKS ticks without a line edge return the device to sleep (`sleep_flag` 1, `core_rst_n` 0). This holds for a line resting high and for a line resting low.
- R7: Every line edge while awake restarts the idle interval. A low pulse of any width while awake is treated as data: no configuration read and no ready break follow.
- R8: A control write is taken only while `core_rst_n` is 1. Write data bit 1 set (soft reset) turns auto-sleep on. Otherwise bit 0 becomes the auto-sleep enable. The enable is 1 after every wake-up sequence, so a write made while asleep has no effect.
- R9: When bit 2 of configuration byte 0 is 0, the device never auto-sleeps, whatever the control enable holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low power-on reset |
| time_tick | input | 1 | One-cycle strobe of the prescaled time base |
| bus_in | input | 1 | Sampled level of the bus wire |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 2 | Bit 0 auto-sleep enable, bit 1 soft reset |
| cfg_rd_valid | output | 1 | Configuration read request |
| cfg_rd_addr | output | OTP_AW | Configuration byte address |
| cfg_rd_ready | input | 1 | Memory accepts the request, data valid |
| cfg_rd_data | input | 8 | Configuration byte read |
| dflt_cfg | output | 8*CFG_BYTES | Loaded default configuration bytes |
| bus_pull_dn | output | 1 | Request to pull the bus wire low |
| core_rst_n | output | 1 | Active-low reset to the device core |
| sleep_flag | output | 1 | Device is asleep |

## Verification
If the shared phase counter is off, the fault shows at the ports within a single tick. `sleep_flag` falls one tick early or late, or the ready break comes out one tick short or long. The bench counts both in ticks against arithmetic expectations. If the loader index is wrong, the first handshake carries a bad address, or `dflt_cfg` holds a misplaced byte by the time the break starts. If the idle counter is not cleared on an edge, or the enable and fuse decoding is wrong, the device sleeps before IDLE_TICKS ticks have passed since the last edge, or stays awake when it should sleep. The bench sees either case within one idle interval.

// File: rtl/swp_pkg.sv
package swp_pkg;

  typedef enum logic [2:0] {
    PS_SLEEP,
    PS_DEGLITCH,
    PS_LOAD,
    PS_RDY_BRK,
    PS_AWAKE
  } pwr_state_e;

  localparam int unsigned BRK_NUM = 1391;
  localparam int unsigned BRK_DEN = 1000;

  // ready break length in ticks, fixed-point ratio rounded up
  function automatic int unsigned ready_brk_ticks(input int unsigned bit_ticks);
    return (bit_ticks * BRK_NUM + BRK_DEN - 1) / BRK_DEN;
  endfunction

endpackage

// File: rtl/swp_edge_det.sv
module swp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o,
  output logic any_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= line_i;
  end

  assign fall_o = prev_q & ~line_i;
  assign any_o  = prev_q ^ line_i;

endmodule

// File: rtl/swp_interval.sv
module swp_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;
  logic         at_end;

  assign at_end   = (cnt_q == limit_i - W'(1));
  assign expire_o = tick_i & at_end;

  // saturates on the last count until cleared
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i)            cnt_q <= '0;
    else if (tick_i && !at_end) cnt_q <= cnt_q + W'(1);
  end

endmodule

// File: rtl/swp_cfg_loader.sv
module swp_cfg_loader #(
  parameter int NBYTES = 2,
  parameter int AW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                rd_valid_o,
  output logic [AW-1:0]       rd_addr_o,
  input  logic                rd_ready_i,
  input  logic [7:0]          rd_data_i,
  output logic [NBYTES*8-1:0] cfg_o,
  output logic                done_o
);

  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;

  logic          busy_q;
  logic [IW-1:0] idx_q;
  logic          last;
  logic          hs;

  assign last       = (idx_q == IW'(NBYTES - 1));
  assign hs         = busy_q & rd_ready_i;
  assign rd_valid_o = busy_q;
  assign rd_addr_o  = AW'(idx_q);
  assign done_o     = hs & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (hs) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + IW'(1);
    end
  end

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          byte_q <= 8'h00;
      else if (hs && idx_q == IW'(g))      byte_q <= rd_data_i;
    end
    assign cfg_o[g*8 +: 8] = byte_q;
  end

endmodule

// File: rtl/swire_power_ctl.sv
module swire_power_ctl
  import swp_pkg::*;
#(
  parameter int unsigned DEGLITCH_TICKS = 20,
  parameter int unsigned BIT_TICKS      = 43,
  parameter int unsigned IDLE_TICKS     = 1000000,
  parameter int unsigned CFG_BYTES      = 2,
  parameter int unsigned OTP_AW         = 4,
  parameter int unsigned FUSE_BIT       = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   time_tick,
  input  logic                   bus_in,
  input  logic                   ctl_wr_en,
  input  logic [1:0]             ctl_wr_data,
  output logic                   cfg_rd_valid,
  output logic [OTP_AW-1:0]      cfg_rd_addr,
  input  logic                   cfg_rd_ready,
  input  logic [7:0]             cfg_rd_data,
  output logic [CFG_BYTES*8-1:0] dflt_cfg,
  output logic                   bus_pull_dn,
  output logic                   core_rst_n,
  output logic                   sleep_flag
);

  localparam int unsigned BRK_TICKS = ready_brk_ticks(BIT_TICKS);
  localparam int unsigned PH_MAX    = (BRK_TICKS > DEGLITCH_TICKS) ? BRK_TICKS : DEGLITCH_TICKS;
  localparam int          PH_W      = $clog2(PH_MAX + 1);
  localparam int          IDLE_W    = $clog2(IDLE_TICKS + 1);
  localparam logic [PH_W-1:0]   DG_LIM   = PH_W'(DEGLITCH_TICKS);
  localparam logic [PH_W-1:0]   BRK_LIM  = PH_W'(BRK_TICKS);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(IDLE_TICKS);

  pwr_state_e state_q, state_d;

  logic line_fall, line_edge;
  logic ph_clr, ph_tick, ph_exp;
  logic [PH_W-1:0] ph_limit;
  logic idle_clr, idle_exp;
  logic load_start, load_done;
  logic auto_en_q, auto_eff;

  swp_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (bus_in),
    .fall_o (line_fall),
    .any_o  (line_edge)
  );

  // shared by the deglitch window and the ready break
  assign ph_limit = (state_q == PS_RDY_BRK) ? BRK_LIM : DG_LIM;
  assign ph_tick  = time_tick & ((state_q == PS_RDY_BRK) | ~bus_in);
  assign ph_clr   = (state_d != state_q);

  swp_interval #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (ph_clr),
    .tick_i   (ph_tick),
    .limit_i  (ph_limit),
    .expire_o (ph_exp)
  );

  assign idle_clr = (state_q != PS_AWAKE) | line_edge;

  swp_interval #(.W(IDLE_W)) u_idle (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (idle_clr),
    .tick_i   (time_tick),
    .limit_i  (IDLE_LIM),
    .expire_o (idle_exp)
  );

  swp_cfg_loader #(.NBYTES(CFG_BYTES), .AW(OTP_AW)) u_load (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (load_start),
    .rd_valid_o (cfg_rd_valid),
    .rd_addr_o  (cfg_rd_addr),
    .rd_ready_i (cfg_rd_ready),
    .rd_data_i  (cfg_rd_data),
    .cfg_o      (dflt_cfg),
    .done_o     (load_done)
  );

  assign auto_eff = auto_en_q & dflt_cfg[FUSE_BIT];

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_SLEEP:    if (line_fall) state_d = PS_DEGLITCH;
      PS_DEGLITCH: begin
        if (bus_in)      state_d = PS_SLEEP;
        else if (ph_exp) state_d = PS_LOAD;
      end
      PS_LOAD:     if (load_done) state_d = PS_RDY_BRK;
      PS_RDY_BRK:  if (ph_exp) state_d = PS_AWAKE;
      PS_AWAKE:    if (idle_exp && auto_eff) state_d = PS_SLEEP;
      default:     state_d = PS_SLEEP;
    endcase
  end

  assign load_start = (state_q == PS_DEGLITCH) && (state_d == PS_LOAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_SLEEP;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      auto_en_q <= 1'b1;
    else if (load_start)             auto_en_q <= 1'b1;
    else if (ctl_wr_en && core_rst_n) auto_en_q <= ctl_wr_data[1] | ctl_wr_data[0];
  end

  assign sleep_flag  = (state_q == PS_SLEEP) || (state_q == PS_DEGLITCH);
  assign core_rst_n  = ~sleep_flag;
  assign bus_pull_dn = (state_q == PS_RDY_BRK);

endmodule

// File: rtl/swp_checker.sv
module swp_checker #(
  parameter int unsigned CFG_BYTES = 2,
  parameter int unsigned OTP_AW    = 4,
  parameter int unsigned FUSE_BIT  = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_in,
  input logic                   cfg_rd_valid,
  input logic                   cfg_rd_ready,
  input logic [OTP_AW-1:0]      cfg_rd_addr,
  input logic [CFG_BYTES*8-1:0] dflt_cfg,
  input logic                   bus_pull_dn,
  input logic                   core_rst_n,
  input logic                   sleep_flag
);

  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd_valid && !cfg_rd_ready |=> cfg_rd_valid && $stable(cfg_rd_addr));

  // R5
  brk_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_pull_dn) |-> $past(cfg_rd_valid && cfg_rd_ready));

  // R3
  wake_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_n) |-> !$past(bus_in));

  // R2
  asleep_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_flag |-> !cfg_rd_valid);

  // R9
  fuse_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n && !bus_pull_dn && !cfg_rd_valid && !dflt_cfg[FUSE_BIT] |=> core_rst_n);

endmodule

bind swire_power_ctl swp_checker #(
  .CFG_BYTES (CFG_BYTES),
  .OTP_AW    (OTP_AW),
  .FUSE_BIT  (FUSE_BIT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_in       (bus_in),
  .cfg_rd_valid (cfg_rd_valid),
  .cfg_rd_ready (cfg_rd_ready),
  .cfg_rd_addr  (cfg_rd_addr),
  .dflt_cfg     (dflt_cfg),
  .bus_pull_dn  (bus_pull_dn),
  .core_rst_n   (core_rst_n),
  .sleep_flag   (sleep_flag)
);

// File: tb/tb_swire_power_ctl.sv
`timescale 1ns/1ps
module tb_swire_power_ctl;

  localparam int DG   = 4;
  localparam int BT   = 7;
  localparam int IDLE = 50;
  localparam int NB   = 2;
  localparam int AW   = 4;
  localparam int BRK  = (BT * 1391 + 999) / 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic time_tick = 1'b0;
  logic host = 1'b0;
  logic bus_in;
  logic ctl_wr_en = 1'b0;
  logic [1:0] ctl_wr_data = 2'b00;
  logic cfg_rd_valid;
  logic [AW-1:0] cfg_rd_addr;
  logic cfg_rd_ready = 1'b0;
  logic [7:0] cfg_rd_data = 8'h00;
  logic [NB*8-1:0] dflt_cfg;
  logic bus_pull_dn, core_rst_n, sleep_flag;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int vcount = 0;
  int pull_rises = 0;
  bit fuse_on = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign bus_in = host & ~bus_pull_dn;

  swire_power_ctl #(
    .DEGLITCH_TICKS (DG), .BIT_TICKS (BT), .IDLE_TICKS (IDLE),
    .CFG_BYTES (NB), .OTP_AW (AW), .FUSE_BIT (2)
  ) dut (
    .clk (clk), .rst_n (rst_n), .time_tick (time_tick), .bus_in (bus_in),
    .ctl_wr_en (ctl_wr_en), .ctl_wr_data (ctl_wr_data),
    .cfg_rd_valid (cfg_rd_valid), .cfg_rd_addr (cfg_rd_addr),
    .cfg_rd_ready (cfg_rd_ready), .cfg_rd_data (cfg_rd_data),
    .dflt_cfg (dflt_cfg), .bus_pull_dn (bus_pull_dn),
    .core_rst_n (core_rst_n), .sleep_flag (sleep_flag)
  );

  function automatic logic [7:0] mem_byte(input int k);
    logic [7:0] b;
    b = 8'(8'h5A + k * 29);
    if (k == 0) b[2] = fuse_on;
    return b;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // prescaled strobe: one cycle in three
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      div = (div == 2) ? 0 : div + 1;
      time_tick <= (div == 0);
    end
  end

  // memory model with stall latency
  initial begin
    int wait_n = 0;
    int exp_idx = 0;
    forever begin
      @(negedge clk);
      if (cfg_rd_ready) begin
        exp_idx = (exp_idx + 1) % NB;
        cfg_rd_ready = 1'b0;
        wait_n = 0;
      end
      if (cfg_rd_valid) begin
        vcount++;
        if (wait_n == lat) begin
          // R4 ascending addresses
          chk(int'(cfg_rd_addr) == exp_idx, "R4 addr", int'(cfg_rd_addr), exp_idx);
          cfg_rd_data = mem_byte(int'(cfg_rd_addr));
          cfg_rd_ready = 1'b1;
        end else wait_n++;
      end
    end
  end

  // ready break monitor
  initial begin
    int brk_n = 0;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_pull_dn && !prev) begin
        logic [NB*8-1:0] e;
        pull_rises++;
        for (int k = 0; k < NB; k++) e[k*8 +: 8] = mem_byte(k);
        // R4 byte placement
        chk(dflt_cfg == e, "R4 cfg", int'(dflt_cfg), int'(e));
        // R5 no read left when break starts
        chk(!cfg_rd_valid, "R5 start", int'(cfg_rd_valid), 0);
      end
      if (bus_pull_dn && time_tick) brk_n++;
      if (!bus_pull_dn && prev) begin
        // R5 length
        chk(brk_n == BRK, "R5 length", brk_n, BRK);
        brk_n = 0;
      end
      prev = bus_pull_dn;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic wait_tick();
    @(negedge clk);
    while (!time_tick) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic ctl_write(input logic [1:0] d);
    @(negedge clk);
    ctl_wr_en = 1'b1;
    ctl_wr_data = d;
    @(negedge clk);
    ctl_wr_en = 1'b0;
  endtask

  task automatic count_until_sleep(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      if (sleep_flag) break;
      if (time_tick) n++;
    end
  endtask

  // returns at the first negedge after the ready break ends
  task automatic do_wake(input int w, input bit hold);
    host = 1'b1;
    wait_tick();
    host = 1'b0;
    wait_ticks(DG - 1);
    chk(sleep_flag == 1'b1, "R3 early", int'(sleep_flag), 1);
    wait_tick();
    chk(sleep_flag == 1'b0 && core_rst_n == 1'b1, "R3 wake", int'(sleep_flag), 0);
    wait_ticks(w - DG);
    if (!hold) host = 1'b1;
    while (!bus_pull_dn) @(negedge clk);
    if (hold) chk(host == 1'b0 && bus_pull_dn, "R5 no wait", int'(host), 0);
    while (bus_pull_dn) @(negedge clk);
  endtask

  initial begin
    int n;
    int vmark, pmark;
    bit t0;
    repeat (3) @(negedge clk);
    // R1
    chk(sleep_flag && !core_rst_n && !bus_pull_dn && !cfg_rd_valid, "R1 in reset", int'(sleep_flag), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sleep_flag && !core_rst_n && !bus_pull_dn && !cfg_rd_valid, "R1 after reset", int'(core_rst_n), 0);

    // R2 idle low, then a rising edge, then idle high
    wait_ticks(2 * IDLE);
    chk(sleep_flag == 1'b1, "R2 idle low", int'(sleep_flag), 1);
    host = 1'b1;
    wait_ticks(2 * IDLE);
    chk(sleep_flag == 1'b1 && vcount == 0, "R2 idle high", vcount, 0);

    // R2 glitch sweep below the deglitch window
    for (int w = 1; w < DG; w++) begin
      wait_tick();
      host = 1'b0;
      wait_ticks(w);
      host = 1'b1;
      wait_ticks(3);
      chk(sleep_flag == 1'b1 && vcount == 0, "R2 glitch", vcount, 0);
    end

    // R3 R5 R6 wakes over widths and memory latencies, idle high
    for (int w = DG; w <= DG + 2; w++) begin
      lat = w - DG;
      do_wake(w, 1'b0);
      count_until_sleep(n);
      chk(n == IDLE, "R6 idle high", n, IDLE);
      chk(!core_rst_n, "R6 core reset", int'(core_rst_n), 0);
    end

    // R5 R6 host holds the line low throughout
    lat = 2;
    do_wake(DG, 1'b1);
    t0 = time_tick;
    count_until_sleep(n);
    n += int'(t0);
    chk(n == IDLE, "R6 idle low", n, IDLE);
    host = 1'b1;
    wait_ticks(3);
    chk(sleep_flag == 1'b1, "R2 rise asleep", int'(sleep_flag), 1);

    // R7 activity restarts the interval; data pulses do not re-wake
    lat = 0;
    do_wake(DG, 1'b0);
    vmark = vcount;
    pmark = pull_rises;
    for (int k = 0; k < 6; k++) begin
      wait_ticks(IDLE / 2 + 5);
      chk(sleep_flag == 1'b0, "R7 kept awake", int'(sleep_flag), 0);
      host = ~host;
    end
    host = 1'b0;
    wait_tick();
    host = 1'b1;
    wait_ticks(5);
    host = 1'b0;
    wait_ticks(DG + 1);
    host = 1'b1;
    chk(vcount == vmark && pull_rises == pmark, "R7 no rewake", pull_rises, pmark);
    count_until_sleep(n);
    chk(n == IDLE, "R7 restart", n, IDLE);

    // R8 soft disable then enable through bit 0
    do_wake(DG, 1'b0);
    ctl_write(2'b00);
    wait_ticks(3 * IDLE);
    chk(sleep_flag == 1'b0, "R8 disabled", int'(sleep_flag), 0);
    ctl_write(2'b01);
    wait_ticks(2);
    chk(sleep_flag == 1'b1, "R8 enable", int'(sleep_flag), 1);

    // R8 soft reset restores the enable
    do_wake(DG, 1'b0);
    ctl_write(2'b00);
    wait_ticks(2 * IDLE);
    chk(sleep_flag == 1'b0, "R8 disabled again", int'(sleep_flag), 0);
    ctl_write(2'b10);
    wait_ticks(2);
    chk(sleep_flag == 1'b1, "R8 soft reset", int'(sleep_flag), 1);

    // R8 write while asleep ignored, enable is 1 after wake-up
    ctl_write(2'b00);
    do_wake(DG, 1'b0);
    count_until_sleep(n);
    chk(n == IDLE, "R8 default on", n, IDLE);

    // R9 fused disable
    rst_n = 1'b0;
    fuse_on = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_wake(DG, 1'b0);
    wait_ticks(3 * IDLE);
    chk(sleep_flag == 1'b0, "R9 fused", int'(sleep_flag), 0);
    ctl_write(2'b01);
    wait_ticks(3 * IDLE);
    chk(sleep_flag == 1'b0, "R9 fused enabled", int'(sleep_flag), 0);

    finish_run();
  end

endmodule